// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache with Software Fence

This block sits between the load/store port of a single in-order processor and one port of a shared memory controller. Cacheable loads and stores are served from a 4-way set-associative array of lines. Stores only mark the line as modified, so memory sees the data later: when the line is evicted, or when software asks for a fence. A fence writes every modified line out and then empties the cache. This lets a DMA master that shares main memory read data the processor has written. It also makes the processor's next reads fetch whatever the DMA master has placed in memory since.

A reserved address window for device command registers is never cached. Accesses inside it pass to the memory side as single-word transfers with their byte enables, and no line is allocated for them. Line traffic on the memory side is one whole line per request/acknowledge transfer. The processor holds a request until the cache acknowledges it. While the request is waiting, a stall output is high.

Top module: `wb_dcache`

## Requirements
- R1: After reset, `cpu_ack`, `mem_req` and `fence_done` are low and every line is invalid.
- R2: A cacheable read miss fetches the containing 16-byte line with exactly one line read. The read then returns the addressed 32-bit word (address bits [3:2] select the word). No acknowledge is given while a line transfer is outstanding.
- R3: A cacheable access that hits completes with `cpu_ack` in the same cycle as the request and causes no memory transfer.
- R4: A store hit writes only the bytes whose `cpu_be` bit is set (bit n covers data bits 8n+7..8n). It marks the line modified and does not access memory.
- R5: A store miss allocates the line (one line read). It then merges the store into the cached copy and does not write memory.
- R6: A miss whose victim is a modified line first writes the old line back to its own address, then fetches the new line.
- R7: Replacement fills an invalid way first (lowest number). Otherwise it takes the victim named by a 3-bit tree pseudo-LRU per set. Root bit 0 picks ways 0–1 when 0 and ways 2–3 when 1. Bit 1 picks way 0 or 1, and bit 2 picks way 2 or 3. Every hit sets the bits along its path to point away from the way it touched.
- R8: While `fence_req` is high, processor requests are stalled. Every modified line is written back. Then all lines are invalidated, and `fence_done` pulses for one cycle with no memory request outstanding.
- R9: After a fence, a read of previously cached data refetches the line from memory, so data a DMA master wrote to memory is returned.
- R10: Lines that are not modified are dropped without a write-back, so a fence with no modified lines makes zero line writes.
- R11: Addresses with `(addr & UNC_MASK) == UNC_BASE` (default: top nibble 0xF) go to memory as single-word transfers (`mem_line` low) carrying `cpu_be` and data in `mem_wdata[31:0]`/`mem_rdata[31:0]`. They never allocate a line, so every such access reaches memory.
- R12: `cpu_stall` is high while a request is waiting, and `cpu_ack` is only given to a pending request. `mem_req` stays high with a stable address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Store byte enables |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending and not yet completed |
| fence_req | input | 1 | Fence request, held until `fence_done` |
| fence_done | output | 1 | One-cycle pulse: write-back and invalidation complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory |
| mem_line | output | 1 | 1 = whole-line transfer, 0 = single word |
| mem_addr | output | 32 | Line-aligned address, or word address for single transfers |
| mem_be | output | 4 | Byte enables for single-word transfers (all ones for lines) |
| mem_wdata | output | 128 | Write line, or word in bits [31:0] |
| mem_rdata | input | 128 | Read line, or word in bits [31:0], valid with `mem_ack` |
| mem_ack | input | 1 | Memory transfer done |

## Verification
Some handshake rules are checked on every cycle. No acknowledge goes to a processor that is not requesting, and none is given while a line transfer is outstanding. A memory request stays stable until it is acknowledged, and single-word transfers only target the device window. The fence-done pulse is one cycle long and quiet on both ports. Other behaviour only the directed scenarios can show, by watching memory traffic and data. This covers which way the pseudo-LRU evicts, and that a fence writes back exactly the modified lines and no clean ones. It also covers byte merging on store hits, the absence of write-through on store misses, and the refetch of DMA-written data after a fence.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_EVICT,
      S_REFILL,
      S_DEV,
      S_SCAN,
      S_FLUSH,
      S_CLEAR
   } dc_state_e;
endpackage

// File: rtl/dc_plru.sv
// Tree pseudo-LRU: victim selection and update after an access.
module dc_plru #(
   parameter int WAYS = 4,
   localparam int WB = $clog2(WAYS),
   localparam int TB = WAYS - 1
) (
   input  logic [TB-1:0] bits_i,
   input  logic [WB-1:0] touch_i,
   output logic [WB-1:0] victim_o,
   output logic [TB-1:0] next_o
);
   generate
      if (WAYS == 4) begin : g_tree4
         always_comb begin
            victim_o = bits_i[0] ? {1'b1, bits_i[2]} : {1'b0, bits_i[1]};
            next_o    = bits_i;
            next_o[0] = ~touch_i[1];
            if (touch_i[1]) next_o[2] = ~touch_i[0];
            else            next_o[1] = ~touch_i[0];
         end
      end else if (WAYS == 2) begin : g_bit
         always_comb begin
            victim_o = bits_i;
            next_o   = ~touch_i;
         end
      end else begin : g_bad
         $error("dc_plru: WAYS must be 2 or 4");
      end
   endgenerate
endmodule

// File: rtl/dc_tag_match.sv
// Per-way tag compare plus lowest-free-way search for one set.
module dc_tag_match #(
   parameter int WAYS  = 4,
   parameter int TAG_B = 22,
   localparam int WB = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_B-1:0] tags_i,
   input  logic [WAYS-1:0]            valid_i,
   input  logic [TAG_B-1:0]           tag_i,
   output logic                       hit_o,
   output logic [WB-1:0]              hit_way_o,
   output logic                       free_o,
   output logic [WB-1:0]              free_way_o
);
   logic [WAYS-1:0] match;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
      end
   endgenerate

   always_comb begin
      hit_way_o  = '0;
      free_way_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w])   hit_way_o  = WB'(w);
         if (!valid_i[w]) free_way_o = WB'(w);
      end
      hit_o  = |match;
      free_o = ~&valid_i;
   end
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
   import dc_pkg::*;
#(
   parameter int SETS       = 64,
   parameter int WAYS       = 4,
   parameter int LINE_WORDS = 4,
   parameter int DW         = 32,
   parameter int AW         = 32,
   parameter logic [AW-1:0] UNC_BASE = 32'hF000_0000,
   parameter logic [AW-1:0] UNC_MASK = 32'hF000_0000,
   localparam int BE_W   = DW / 8,
   localparam int LINE_W = DW * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [BE_W-1:0]   cpu_be,
   input  logic [AW-1:0]     cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   output logic [DW-1:0]     cpu_rdata,
   output logic              cpu_ack,
   output logic              cpu_stall,
   input  logic              fence_req,
   output logic              fence_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_line,
   output logic [AW-1:0]     mem_addr,
   output logic [BE_W-1:0]   mem_be,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int BYTE_B = $clog2(BE_W);
   localparam int WSEL_B = $clog2(LINE_WORDS);
   localparam int OFF_B  = BYTE_B + WSEL_B;
   localparam int IDX_B  = $clog2(SETS);
   localparam int TAG_B  = AW - IDX_B - OFF_B;
   localparam int WAY_B  = $clog2(WAYS);
   localparam int ENT    = SETS * WAYS;
   localparam int ENT_B  = IDX_B + WAY_B;
   localparam int TB     = WAYS - 1;

   generate
      if (DW % 8 != 0) begin : g_bad_dw
         $error("wb_dcache: DW must be a multiple of 8");
      end
      if ((1 << IDX_B) != SETS) begin : g_bad_sets
         $error("wb_dcache: SETS must be a power of two");
      end
      if ((1 << WSEL_B) != LINE_WORDS) begin : g_bad_line
         $error("wb_dcache: LINE_WORDS must be a power of two");
      end
   endgenerate

   dc_state_e          st_q;
   logic [TAG_B-1:0]   tag_q  [ENT];
   logic [LINE_W-1:0]  line_q [ENT];
   logic [ENT-1:0]     val_q, dty_q;
   logic [TB-1:0]      lru_q  [SETS];
   logic [WAY_B-1:0]   vic_q;
   logic [ENT_B-1:0]   scan_q;

   // request decode
   logic [IDX_B-1:0]   r_idx;
   logic [TAG_B-1:0]   r_tag;
   logic [WSEL_B-1:0]  r_wsel;
   logic               in_window;
   assign r_idx     = cpu_addr[OFF_B +: IDX_B];
   assign r_tag     = cpu_addr[AW-1 -: TAG_B];
   assign r_wsel    = cpu_addr[BYTE_B +: WSEL_B];
   assign in_window = (cpu_addr & UNC_MASK) == UNC_BASE;

   // set view
   logic [WAYS-1:0][TAG_B-1:0] set_tags;
   logic [WAYS-1:0]            set_val;
   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         set_tags[w] = tag_q[{r_idx, WAY_B'(w)}];
         set_val[w]  = val_q[{r_idx, WAY_B'(w)}];
      end
   end

   logic             hit, has_free;
   logic [WAY_B-1:0] hit_way, free_way, lru_vic, pick_way;
   logic [TB-1:0]    lru_next;

   dc_tag_match #(.WAYS(WAYS), .TAG_B(TAG_B)) match_i (
      .tags_i     (set_tags),
      .valid_i    (set_val),
      .tag_i      (r_tag),
      .hit_o      (hit),
      .hit_way_o  (hit_way),
      .free_o     (has_free),
      .free_way_o (free_way)
   );

   dc_plru #(.WAYS(WAYS)) plru_i (
      .bits_i   (lru_q[r_idx]),
      .touch_i  (hit_way),
      .victim_o (lru_vic),
      .next_o   (lru_next)
   );

   assign pick_way = has_free ? free_way : lru_vic;

   logic [ENT_B-1:0]  hit_e, vic_e, pick_e;
   logic [LINE_W-1:0] hit_line, merged;
   logic [DW-1:0]     hit_word;
   logic              lookup_hit;
   assign hit_e    = {r_idx, hit_way};
   assign vic_e    = {r_idx, vic_q};
   assign pick_e   = {r_idx, pick_way};
   assign hit_line = line_q[hit_e];
   assign hit_word = hit_line[r_wsel*DW +: DW];
   assign lookup_hit = (st_q == S_IDLE) && !fence_req && cpu_req && !in_window && hit;

   always_comb begin
      merged = hit_line;
      for (int b = 0; b < BE_W; b++) begin
         if (cpu_be[b]) merged[r_wsel*DW + b*8 +: 8] = cpu_wdata[b*8 +: 8];
      end
   end

   // port outputs
   always_comb begin
      cpu_ack    = lookup_hit || ((st_q == S_DEV) && mem_ack);
      cpu_rdata  = (st_q == S_DEV) ? mem_rdata[DW-1:0] : hit_word;
      cpu_stall  = cpu_req && !cpu_ack;
      fence_done = (st_q == S_CLEAR);
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_line   = 1'b1;
      mem_addr   = '0;
      mem_be     = '1;
      mem_wdata  = '0;
      case (st_q)
         S_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {tag_q[vic_e], r_idx, {OFF_B{1'b0}}};
            mem_wdata = line_q[vic_e];
         end
         S_REFILL: begin
            mem_req  = 1'b1;
            mem_addr = {r_tag, r_idx, {OFF_B{1'b0}}};
         end
         S_DEV: begin
            mem_req   = 1'b1;
            mem_we    = cpu_we;
            mem_line  = 1'b0;
            mem_addr  = cpu_addr;
            mem_be    = cpu_be;
            mem_wdata = LINE_W'(cpu_wdata);
         end
         S_FLUSH: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {tag_q[scan_q], scan_q[ENT_B-1 -: IDX_B], {OFF_B{1'b0}}};
            mem_wdata = line_q[scan_q];
         end
         default: ;
      endcase
   end

   // control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         val_q  <= '0;
         dty_q  <= '0;
         vic_q  <= '0;
         scan_q <= '0;
         for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (fence_req) begin
                  scan_q <= '0;
                  st_q   <= S_SCAN;
               end else if (cpu_req) begin
                  if (in_window) begin
                     st_q <= S_DEV;
                  end else if (hit) begin
                     lru_q[r_idx] <= lru_next;
                     if (cpu_we) dty_q[hit_e] <= 1'b1;
                  end else begin
                     vic_q <= pick_way;
                     st_q  <= (val_q[pick_e] && dty_q[pick_e]) ? S_EVICT : S_REFILL;
                  end
               end
            end
            S_EVICT:  if (mem_ack) st_q <= S_REFILL;
            S_REFILL: if (mem_ack) begin
               val_q[vic_e] <= 1'b1;
               dty_q[vic_e] <= 1'b0;
               st_q         <= S_IDLE;
            end
            S_DEV:    if (mem_ack) st_q <= S_IDLE;
            S_SCAN: begin
               if (val_q[scan_q] && dty_q[scan_q]) st_q <= S_FLUSH;
               else if (scan_q == ENT_B'(ENT - 1)) st_q <= S_CLEAR;
               else scan_q <= scan_q + 1'b1;
            end
            S_FLUSH:  if (mem_ack) begin
               dty_q[scan_q] <= 1'b0;
               st_q          <= S_SCAN;
            end
            S_CLEAR: begin
               val_q <= '0;
               dty_q <= '0;
               st_q  <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // line storage
   always_ff @(posedge clk) begin
      if (st_q == S_REFILL && mem_ack) begin
         line_q[vic_e] <= mem_rdata;
         tag_q[vic_e]  <= r_tag;
      end else if (lookup_hit && cpu_we) begin
         line_q[hit_e] <= merged;
      end
   end
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
   parameter int AW = 32,
   parameter logic [AW-1:0] UNC_BASE = '0,
   parameter logic [AW-1:0] UNC_MASK = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_ack,
   input logic          fence_done,
   input logic          mem_req,
   input logic          mem_ack,
   input logic          mem_line,
   input logic [AW-1:0] mem_addr
);
   a_r12_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> cpu_req);

   a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   a_r11_single_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_line |-> ((mem_addr & UNC_MASK) == UNC_BASE));

   a_r2_no_ack_during_line: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_line |-> !cpu_ack);

   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |-> !mem_req && !cpu_ack);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |=> !fence_done);
endmodule

bind wb_dcache dc_checker #(
   .AW(AW), .UNC_BASE(UNC_BASE), .UNC_MASK(UNC_MASK)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
   .fence_done(fence_done), .mem_req(mem_req), .mem_ack(mem_ack),
   .mem_line(mem_line), .mem_addr(mem_addr)
);

// File: tb/wb_dcache_tb_top.sv
module wb_dcache_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0, cpu_we = 1'b0;
   logic [3:0]   cpu_be = '0;
   logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_ack, cpu_stall;
   logic         fence_req = 1'b0, fence_done;
   logic         mem_req, mem_we, mem_line;
   logic [31:0]  mem_addr;
   logic [3:0]   mem_be;
   logic [127:0] mem_wdata;
   logic [127:0] mem_rdata = '0;
   logic         mem_ack = 1'b0;

   always #2 clk = ~clk;

   wb_dcache dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
      .fence_req(fence_req), .fence_done(fence_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // memory and device model
   logic [31:0] mem [4096];
   logic [31:0] cmd_reg = '0;
   logic [31:0] last_wb = '0;
   int rd_cnt = 0, wb_cnt = 0, dev_rd = 0, dev_wr = 0, lat = 0, base = 0;
   int n_chk = 0, n_bad = 0;
   logic [31:0] merged_word = '0;

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         lat = 0;
      end else if (mem_req) begin
         lat++;
         if (lat == 2) begin
            base = int'(mem_addr[13:4]) * 4;
            if (mem_line) begin
               if (mem_we) begin
                  for (int k = 0; k < 4; k++) mem[base + k] = mem_wdata[k*32 +: 32];
                  wb_cnt++;
                  last_wb = mem_addr;
               end else begin
                  for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = mem[base + k];
                  rd_cnt++;
               end
            end else begin
               if (mem_we) begin
                  for (int b = 0; b < 4; b++) if (mem_be[b]) cmd_reg[b*8 +: 8] = mem_wdata[b*8 +: 8];
                  dev_wr++;
               end else begin
                  mem_rdata = {96'h0, cmd_reg};
                  dev_rd++;
               end
            end
            mem_ack = 1'b1;
         end
      end
   end

   function automatic logic [31:0] adr(input int t, input int s, input int w);
      return 32'((t << 10) | (s << 4) | (w << 2));
   endfunction

   function automatic logic [31:0] mw(input logic [31:0] a);
      return mem[a[13:2]];
   endfunction

   task automatic check(input string id, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", id, got, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [3:0] be, input logic [31:0] a,
                      input logic [31:0] wd, output logic [31:0] rd, output logic stl);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = wd;
      #1;
      stl = cpu_stall;
      while (!cpu_ack) begin
         @(negedge clk);
         #1;
      end
      rd = cpu_rdata;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic do_fence();
      @(negedge clk);
      fence_req = 1'b1;
      #1;
      while (!fence_done) begin
         @(negedge clk);
         #1;
      end
      check("R8 fence done seen", {31'h0, fence_done}, 32'h1);
      @(negedge clk);
      fence_req = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ack after reset", {31'h0, cpu_ack}, 32'h0);
      check("R1 mem_req after reset", {31'h0, mem_req}, 32'h0);
      check("R1 fence_done after reset", {31'h0, fence_done}, 32'h0);
   endtask

   task automatic t_read();
      logic [31:0] d; logic s; int r0;
      r0 = rd_cnt;
      acc(1'b0, 4'h0, adr(1, 5, 2), 32'h0, d, s);
      check("R2 miss data", d, mw(adr(1, 5, 2)));
      check("R2 one line read", 32'(rd_cnt - r0), 32'd1);
      check("R12 stall on miss", {31'h0, s}, 32'h1);
      acc(1'b0, 4'h0, adr(1, 5, 2), 32'h0, d, s);
      check("R3 hit data", d, mw(adr(1, 5, 2)));
      check("R3 hit no traffic", 32'(rd_cnt - r0), 32'd1);
      check("R3 hit no stall", {31'h0, s}, 32'h0);
   endtask

   task automatic t_bytes();
      logic [31:0] d, old; logic s; int r0, w0;
      old = mw(adr(1, 5, 2));
      r0 = rd_cnt; w0 = wb_cnt;
      acc(1'b1, 4'b0010, adr(1, 5, 2), 32'h5566_AB77, d, s);
      check("R4 store hit no stall", {31'h0, s}, 32'h0);
      merged_word = {old[31:16], 8'hAB, old[7:0]};
      acc(1'b0, 4'h0, adr(1, 5, 2), 32'h0, d, s);
      check("R4 byte merge", d, merged_word);
      check("R4 no traffic", 32'((rd_cnt - r0) + (wb_cnt - w0)), 32'd0);
   endtask

   task automatic t_alloc();
      logic [31:0] d, old; logic s; int r0, w0;
      old = mw(adr(2, 7, 1));
      r0 = rd_cnt; w0 = wb_cnt;
      acc(1'b1, 4'hF, adr(2, 7, 1), 32'hCAFE_0001, d, s);
      check("R5 allocate read", 32'(rd_cnt - r0), 32'd1);
      check("R5 no write", 32'(wb_cnt - w0), 32'd0);
      acc(1'b0, 4'h0, adr(2, 7, 1), 32'h0, d, s);
      check("R5 store visible", d, 32'hCAFE_0001);
      check("R5 memory untouched", mw(adr(2, 7, 1)), old);
   endtask

   task automatic t_victim();
      logic [31:0] d; logic s; int r0, w0;
      for (int t = 1; t <= 4; t++) acc(1'b1, 4'hF, adr(t, 9, 0), 32'(t) * 32'h1111_1111, d, s);
      r0 = rd_cnt;
      acc(1'b0, 4'h0, adr(1, 9, 0), 32'h0, d, s);
      check("R7 way0 hit", d, 32'h1111_1111);
      check("R7 way0 no refetch", 32'(rd_cnt - r0), 32'd0);
      w0 = wb_cnt;
      acc(1'b0, 4'h0, adr(5, 9, 0), 32'h0, d, s);
      check("R6 dirty victim written", 32'(wb_cnt - w0), 32'd1);
      check("R7 victim is way2", last_wb, adr(3, 9, 0));
      check("R6 new line data", d, mw(adr(5, 9, 0)));
      check("R6 victim data in memory", mw(adr(3, 9, 0)), 32'h3333_3333);
      r0 = rd_cnt;
      acc(1'b0, 4'h0, adr(2, 9, 0), 32'h0, d, s);
      check("R7 way1 kept", d, 32'h2222_2222);
      check("R7 way1 no refetch", 32'(rd_cnt - r0), 32'd0);
   endtask

   task automatic t_fence();
      logic [31:0] d; logic s; int r0, w0;
      w0 = wb_cnt;
      do_fence();
      check("R8 dirty lines written", 32'(wb_cnt - w0), 32'd5);
      check("R8 store reached memory", mw(adr(2, 7, 1)), 32'hCAFE_0001);
      check("R8 merged bytes in memory", mw(adr(1, 5, 2)), merged_word);
      mem[adr(2, 7, 1) >> 2 & 32'hFFF] = 32'h0D0A_0D0A;
      r0 = rd_cnt;
      acc(1'b0, 4'h0, adr(2, 7, 1), 32'h0, d, s);
      check("R9 refetch after fence", 32'(rd_cnt - r0), 32'd1);
      check("R9 sees DMA data", d, 32'h0D0A_0D0A);
      w0 = wb_cnt;
      do_fence();
      check("R10 clean line dropped", 32'(wb_cnt - w0), 32'd0);
   endtask

   task automatic t_device();
      logic [31:0] d; logic s; int r0, dr0, dw0;
      r0 = rd_cnt; dr0 = dev_rd; dw0 = dev_wr;
      acc(1'b1, 4'b0101, 32'hF000_0010, 32'h1122_3344, d, s);
      check("R11 device write", 32'(dev_wr - dw0), 32'd1);
      acc(1'b0, 4'hF, 32'hF000_0010, 32'h0, d, s);
      check("R11 device byte enables", d, 32'h0022_0044);
      acc(1'b0, 4'hF, 32'hF000_0010, 32'h0, d, s);
      check("R11 no allocation", 32'(dev_rd - dr0), 32'd2);
      check("R11 no line fetch", 32'(rd_cnt - r0), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 32'h1357_0000 ^ 32'(i * 32'h0001_0101);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_read();
      t_bytes();
      t_alloc();
      t_victim();
      t_fence();
      t_device();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule